// File: doc/BRIEF.md
# Configurable Pin Cell Bank

This block sits between the core logic and a row of package pins. Each pin has a cell that takes one logic output and one product-term enable from the core. It drives the pin as three separate signals: an output level, an output enable and an open-drain flag that the surrounding pad or testbench resolves. Whatever level is present on the pin comes back as a combinational input to the routing network, whatever the mode of the cell.

Every cell holds a 5-bit configuration word, written one pin at a time through a small write port. The word sets the direction of the cell: input only, output only, or bidirectional with three-state control. It also sets the drive style, totem-pole or open drain. Finally it chooses where the enable of a bidirectional cell comes from: the product-term enable of that pin, or one of two chip-wide enable inputs, both active high. Reset puts every cell into the erased state, which is input only with totem-pole drive.

The configuration word `cfg_wdata` uses these fields. Bits [1:0] hold the direction: 00 is input only, 01 is output only, 10 is bidirectional and 11 is reserved. Bit [2] sets the drive style: 0 is totem-pole and 1 is open drain. Bits [4:3] choose the enable source: 00 is the product-term enable, 01 is global enable 0, 10 is global enable 1 and 11 is reserved.

Top module: `iocell_bank`

## Requirements
- R1: After reset every cell holds configuration 5'b00000, so every `pad_oe` and every `pad_od` bit is 0.
- R2: When `cfg_we` is 1 at a rising clock edge, the pin indexed by `cfg_sel` takes `cfg_wdata`, and the new configuration acts on the outputs from that edge on. The other pins keep their configuration, and an index of `NUM_PINS` or above changes no pin.
- R3: In input-only mode (bits [1:0] = 00), `pad_oe` of the pin is 0 whatever its data and enable inputs are.
- R4: In output-only mode (bits [1:0] = 01), the enable of the pin is always active and ignores the selected enable source.
- R5: In bidirectional mode (bits [1:0] = 10), the enable of the pin follows the selected enable source.
- R6: The enable source field selects as follows: 00 gives `core_oe` of the pin, 01 gives `gbl_oe0` and 10 gives `gbl_oe1`. All three are active high.
- R7: With totem-pole drive (bit [2] = 0), `pad_o` equals `core_data`, `pad_oe` equals the enable of the pin, and `pad_od` is 0.
- R8: With open-drain drive (bit [2] = 1), `pad_o` is 0 and `pad_od` is 1. `pad_oe` is 1 only when the enable of the pin is active and `core_data` is 0, so a data value of 1 releases the pin.
- R9: `route_in` equals `pad_i` for every pin in every mode.
- R10: The reserved direction code 11 behaves as input only, and the reserved enable source code 11 selects `core_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low reset to the erased configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IDX_W | Index of the pin being configured |
| cfg_wdata | input | 5 | Configuration word (fields as above) |
| core_data | input | NUM_PINS | Logic output to drive on each pin |
| core_oe | input | NUM_PINS | Product-term enable of each pin, active high |
| gbl_oe0 | input | 1 | Chip-wide enable 0, active high |
| gbl_oe1 | input | 1 | Chip-wide enable 1, active high |
| pad_i | input | NUM_PINS | Level present on each pin |
| pad_o | output | NUM_PINS | Level driven onto each pin |
| pad_oe | output | NUM_PINS | Driver enable of each pin |
| pad_od | output | NUM_PINS | Open-drain flag of each pin |
| route_in | output | NUM_PINS | Pin level forwarded to the routing network |

## Verification
Only a configuration write passes through a register. Its effect on `pad_o`, `pad_oe` and `pad_od` is due just after the rising edge that samples `cfg_we`, so the bench updates its model at that edge and samples 1 ns later, before the next falling edge. The data, enable and `pad_i` inputs reach the outputs with no clock in between. The bench changes these inputs on the falling edge and compares every pin against its model after the following rising edge. By then all combinational paths have settled, and the configuration of the pin is the one written at that same edge.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_BIDIR  = 2'b10,
    PM_RSVD   = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    OES_PTERM = 2'b00,
    OES_GLB0  = 2'b01,
    OES_GLB1  = 2'b10,
    OES_RSVD  = 2'b11
  } oe_src_e;

  typedef struct packed {
    oe_src_e   oe_src;
    logic      open_drain;
    pin_mode_e mode;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  localparam pin_cfg_t CFG_ERASED = '{oe_src: OES_PTERM, open_drain: 1'b0, mode: PM_INPUT};

  // Chooses the enable named by the source field; the reserved code falls back to the product term.
  function automatic logic pick_enable(oe_src_e src, logic pt_oe, logic g0, logic g1);
    case (src)
      OES_GLB0: return g0;
      OES_GLB1: return g1;
      default:  return pt_oe;
    endcase
  endfunction

  // Combines the direction with the selected enable; reserved direction acts as input only.
  function automatic logic mode_gate(pin_mode_e mode, logic sel_en);
    case (mode)
      PM_OUTPUT: return 1'b1;
      PM_BIDIR:  return sel_en;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/iocell_cfg_reg.sv
module iocell_cfg_reg
  import iocell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pin_cfg_t wr_data,
  output pin_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= CFG_ERASED;
    else if (wr_en) cfg_q <= wr_data;
  end

  assert_erased_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_q == CFG_ERASED));

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

  assert_load_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data)));

endmodule

// File: rtl/iocell_oe_sel.sv
module iocell_oe_sel
  import iocell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cfg_t cfg,
  input  logic     pt_oe,
  input  logic     g0,
  input  logic     g1,
  output logic     sel_en,
  output logic     drive_gate
);

  always_comb begin
    sel_en     = pick_enable(cfg.oe_src, pt_oe, g0, g1);
    drive_gate = mode_gate(cfg.mode, sel_en);
  end

  assert_input_never_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == PM_INPUT || cfg.mode == PM_RSVD) |-> !drive_gate);

  assert_output_always_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == PM_OUTPUT) |-> drive_gate);

  assert_bidir_follows_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == PM_BIDIR) |-> (drive_gate == sel_en));

  assert_glb0_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.oe_src == OES_GLB0) |-> (sel_en == g0));

endmodule

// File: rtl/iocell_driver.sv
module iocell_driver
  import iocell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic open_drain,
  input  logic data,
  input  logic gate,
  output logic pad_o,
  output logic pad_oe,
  output logic pad_od
);

  always_comb begin
    pad_od = open_drain;
    if (open_drain) begin
      pad_o  = 1'b0;
      pad_oe = gate & ~data;
    end else begin
      pad_o  = data;
      pad_oe = gate;
    end
  end

  assert_totem_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !open_drain |-> (pad_o == data && pad_oe == gate && !pad_od));

  assert_od_never_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    open_drain |-> (!pad_o && pad_od && !(pad_oe && data) && !(pad_oe && !gate)));

endmodule

// File: rtl/iocell_bank.sv
module iocell_bank
  import iocell_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_sel,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic [NUM_PINS-1:0] core_data,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic                gbl_oe0,
  input  logic                gbl_oe1,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_od,
  output logic [NUM_PINS-1:0] route_in
);

  pin_cfg_t wr_word;
  assign wr_word = pin_cfg_t'(cfg_wdata);

  // The pin level is forwarded unconditionally, including while the cell drives it.
  assign route_in = pad_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    logic     wr_hit;
    pin_cfg_t cfg_q;
    logic     sel_en;
    logic     drive_gate;

    assign wr_hit = cfg_we && (cfg_sel == IDX_W'(i));

    iocell_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hit),
      .wr_data (wr_word),
      .cfg_q   (cfg_q)
    );

    iocell_oe_sel u_oe (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg_q),
      .pt_oe      (core_oe[i]),
      .g0         (gbl_oe0),
      .g1         (gbl_oe1),
      .sel_en     (sel_en),
      .drive_gate (drive_gate)
    );

    iocell_driver u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_drain (cfg_q.open_drain),
      .data       (core_data[i]),
      .gate       (drive_gate),
      .pad_o      (pad_o[i]),
      .pad_oe     (pad_oe[i]),
      .pad_od     (pad_od[i])
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pad_oe[i] && !pad_od[i]));

    assert_reserved_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.mode == PM_RSVD) |-> !pad_oe[i]);
  end

  assert_route_tracks_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    route_in == pad_i);

endmodule

// File: tb/sim_iocell_bank.sv
module sim_iocell_bank;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [4:0]    cfg_wdata = '0;
  logic [N-1:0]  core_data = '0, core_oe = '0, pad_i = '0;
  logic          gbl_oe0 = 1'b0, gbl_oe1 = 1'b0;
  logic [N-1:0]  pad_o, pad_oe, pad_od, route_in;

  logic [4:0] model [N];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  iocell_bank #(.NUM_PINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .core_data(core_data), .core_oe(core_oe), .gbl_oe0(gbl_oe0), .gbl_oe1(gbl_oe1),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_od(pad_od), .route_in(route_in)
  );

  // Expected {pad_o, pad_oe, pad_od}, restated from the field table.
  function automatic logic [2:0] ref_pin(logic [4:0] c, logic d, logic pt, logic g0, logic g1);
    logic en, gate;
    en = (c[4:3] == 2'b01) ? g0 : (c[4:3] == 2'b10) ? g1 : pt;
    if (c[1:0] == 2'b01)      gate = 1'b1;
    else if (c[1:0] == 2'b10) gate = en;
    else                      gate = 1'b0;
    if (c[2]) return {1'b0, gate && !d, 1'b1};
    return {d, gate, 1'b0};
  endfunction

  function automatic string tag_of(logic [4:0] c);
    if (c[1:0] == 2'b11 || c[4:3] == 2'b11) return "R10";
    if (c[2]) return "R8";
    if (c[1:0] == 2'b00) return "R3";
    if (c[1:0] == 2'b01) return "R4";
    return "R5/R6/R7";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string note);
    for (int i = 0; i < N; i++) begin
      logic [2:0] e;
      e = ref_pin(model[i], core_data[i], core_oe[i], gbl_oe0, gbl_oe1);
      check($sformatf("%s pin%0d %s", tag_of(model[i]), i, note),
            {29'd0, pad_o[i], pad_oe[i], pad_od[i]}, {29'd0, e});
    end
    check("R9 route", route_in, pad_i);
  endtask

  // Drives one step at the falling edge; a write takes effect at the next rising edge.
  task automatic step(logic we, logic [IW-1:0] sel, logic [4:0] w,
                      logic [N-1:0] d, logic [N-1:0] pt, logic g0, logic g1, logic [N-1:0] pin);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = w;
    core_data = d; core_oe = pt; gbl_oe0 = g0; gbl_oe1 = g1; pad_i = pin;
    @(posedge clk);
    if (we && int'(sel) < N) model[sel] = w;
    #1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 5'b00000;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    core_data = '1; core_oe = '1; gbl_oe0 = 1'b1; gbl_oe1 = 1'b1; pad_i = 8'hA5;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: erased state with every enable asserted
    check("R1 oe after reset", pad_oe, '0);
    check("R1 od after reset", pad_od, '0);
    check_all("reset");

    // R2: write pin 3 only, others untouched
    step(1'b1, 3'd3, 5'b00001, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h3C);
    check("R2 only pin3 enabled", pad_oe, 8'h08);
    check("R4 output ignores pterm", {31'd0, pad_oe[3]}, 32'd1);
    // R6: each enable source in bidirectional mode on pin 0
    step(1'b1, 3'd0, 5'b01010, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
    check("R6 glb0 source", {31'd0, pad_oe[0]}, 32'd1);
    step(1'b1, 3'd0, 5'b10010, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
    check("R6 glb1 source", {31'd0, pad_oe[0]}, 32'd0);
    step(1'b0, 3'd0, 5'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00);
    check("R6 glb1 source high", {31'd0, pad_oe[0]}, 32'd1);
    // R8: open-drain output releases on 1, pulls on 0
    step(1'b1, 3'd1, 5'b00101, 8'h02, 8'h00, 1'b0, 1'b0, 8'h00);
    check("R8 od release", {29'd0, pad_o[1], pad_oe[1], pad_od[1]}, 32'b001);
    step(1'b0, 3'd0, 5'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);
    check("R8 od pull low", {29'd0, pad_o[1], pad_oe[1], pad_od[1]}, 32'b011);
    // R10: reserved direction and reserved source
    step(1'b1, 3'd2, 5'b00011, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h00);
    check("R10 reserved mode quiet", {31'd0, pad_oe[2]}, 32'd0);
    step(1'b1, 3'd2, 5'b11010, 8'hFF, 8'h04, 1'b0, 1'b0, 8'h00);
    check("R10 reserved src uses pterm", {31'd0, pad_oe[2]}, 32'd1);
    check_all("directed");

    for (int k = 0; k < 400; k++) begin
      step(($urandom % 3) == 0, IW'($urandom), 5'($urandom),
           N'($urandom), N'($urandom), 1'($urandom), 1'($urandom), N'($urandom));
      check_all("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule